// File: doc/BRIEF.md
# Iterative Feistel Block Cipher Engine

This block encrypts or decrypts one 64-bit block at a time with a 16-round Feistel network. The block is split into two 32-bit halves. Each round mixes the left half with a round subkey, runs the result through a mixing function built from four byte-indexed 256-entry tables, and folds the function output into the other half. One round is performed per clock. Both directions share a single datapath: decryption only walks the subkey array from the other end.

The subkey array (18 words), the raw key (14 words) and the four tables are all written through one narrow load port before use. The engine never modifies them. Each subkey is combined with a raw key word when it is read out, and the key words are reused cyclically. A caller loads the tables, the subkey array and the key, then pulses `start` with a block and a direction. A one-cycle `done` pulse marks the result on `blk_out`, and that result stays there until the next operation completes.

Top module: `fcx_cipher_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `done` and `busy` are 0 and `blk_out` is all zeros.
- R2: A `start` sampled while idle makes `busy` high from the next cycle on. `done` is high for exactly one cycle, the 17th cycle after the sampling edge, and `busy` falls in that same cycle.
- R3: A `start` pulse sampled while `busy` is high is ignored. It produces no additional `done` and does not alter the running operation.
- R4: With `decrypt`=0 the result is computed as follows. The halves are L=blk[63:32] and R=blk[31:0]. For rounds r=0..15: x=L^K[r], L=R^F(x), R=x. The result is {R^K[17], L^K[16]}, with K indexed from 0.
- R5: With `decrypt`=1 the same rounds use K[17-r], and the result is {R^K[0], L^K[1]}. Decrypting an encrypted block returns the original block.
- R6: F(x) = ((T0[x[31:24]] + T1[x[23:16]]) ^ T2[x[15:8]]) + T3[x[7:0]], where both additions wrap modulo 2^32.
- R7: The effective subkey K[i] is S[i] ^ W[i mod 14]. S is the stored subkey array (18 words) and W is the stored key (14 words).
- R8: A load write is made with `ld_we`=1, and `ld_sel` selects the target: 0 to 3 write table T0 to T3 at `ld_addr`, 4 writes S[`ld_addr`] for addresses 0 to 17, and 5 writes W[`ld_addr`] for addresses 0 to 13. Writes with other `ld_sel` values or out-of-range addresses change nothing.
- R9: A load write sampled while `busy` is high changes no stored word.
- R10: The direction and input block are captured when `start` is accepted, so later changes on those inputs do not affect the result. `blk_out` changes only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| decrypt | input | 1 | Direction: 0 encrypt, 1 decrypt |
| blk_in | input | 64 | Input block, left half in the upper 32 bits |
| ld_we | input | 1 | Load write strobe |
| ld_sel | input | 3 | Load target: 0-3 tables, 4 subkeys, 5 key words |
| ld_addr | input | 8 | Load word address |
| ld_data | input | 32 | Load write data |
| blk_out | output | 64 | Result block, held until the next completion |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |

## Verification
The assertions assume that `rst` is held for at least one clock before any traffic and that `start` and `ld_we` are clean single-cycle levels sampled at the rising edge. Under these assumptions, the round counter advances by exactly one per running cycle and stored words stay unchanged whenever `busy` was high. The stimulus drives every input half a cycle away from the sampling edge and holds reset for several cycles. It also deliberately injects `start` pulses and load writes in the middle of running operations, so that the rules for ignoring them are exercised rather than avoided.

// File: rtl/fcx_pkg.sv
package fcx_pkg;
    localparam int HALF_W  = 32;
    localparam int ROUNDS  = 16;
    localparam int NSUB    = ROUNDS + 2;
    localparam int NKEY    = 14;
    localparam int NTBL    = 4;
    localparam int TBL_AW  = 8;
    localparam int SEL_W   = 3;
    localparam int CNT_W   = $clog2(ROUNDS);
    localparam int IDX_W   = $clog2(NSUB);
    localparam int KIDX_W  = $clog2(NKEY);

    typedef logic [HALF_W-1:0] word_t;

    typedef struct packed {
        word_t l;
        word_t r;
    } halves_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } phase_e;

    localparam logic [SEL_W-1:0] SEL_SUB = SEL_W'(4);
    localparam logic [SEL_W-1:0] SEL_KEY = SEL_W'(5);

    // subkey slot used by a round in either direction
    function automatic logic [IDX_W-1:0] round_slot(input logic [CNT_W-1:0] rnd,
                                                    input logic dec);
        return dec ? (IDX_W'(NSUB - 1) - IDX_W'(rnd)) : IDX_W'(rnd);
    endfunction

    // combine the four table outputs
    function automatic word_t mix4(input word_t a, input word_t b,
                                   input word_t c, input word_t d);
        return ((a + b) ^ c) + d;
    endfunction
endpackage

// File: rtl/fcx_table_bank.sv
module fcx_table_bank
    import fcx_pkg::*;
(
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [TBL_AW-1:0]    wr_addr,
    input  word_t                wr_data,
    input  word_t                x,
    output word_t                fx
);
    localparam int DEPTH = 1 << TBL_AW;

    word_t look [NTBL];

    for (genvar t = 0; t < NTBL; t++) begin : g_tbl
        word_t mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && wr_sel == SEL_W'(t))
                mem[wr_addr] <= wr_data;
        end
        assign look[t] = mem[x[HALF_W-1-TBL_AW*t -: TBL_AW]];
    end

    assign fx = mix4(look[0], look[1], look[2], look[3]);
endmodule

// File: rtl/fcx_key_store.sv
module fcx_key_store
    import fcx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 busy_i,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [TBL_AW-1:0]    wr_addr,
    input  word_t                wr_data,
    input  logic [IDX_W-1:0]     idx_a,
    input  logic [IDX_W-1:0]     idx_b,
    output word_t                key_a,
    output word_t                key_b
);
    logic [NSUB-1:0][HALF_W-1:0] sub_q;
    logic [NKEY-1:0][HALF_W-1:0] raw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            raw_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_SUB && wr_addr < TBL_AW'(NSUB))
                sub_q[wr_addr[IDX_W-1:0]] <= wr_data;
            if (wr_sel == SEL_KEY && wr_addr < TBL_AW'(NKEY))
                raw_q[wr_addr[KIDX_W-1:0]] <= wr_data;
        end
    end

    function automatic word_t folded(input logic [IDX_W-1:0] i);
        int unsigned k;
        k = int'(i) % NKEY;
        return sub_q[i] ^ raw_q[KIDX_W'(k)];
    endfunction

    assign key_a = folded(idx_a);
    assign key_b = folded(idx_b);

    // R9
    sub_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> $stable(sub_q));
    // R9
    key_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> $stable(raw_q));
endmodule

// File: rtl/fcx_round_ctrl.sv
module fcx_round_ctrl
    import fcx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              accept_o,
    output phase_e            phase_o,
    output logic [CNT_W-1:0]  rnd_o,
    output logic              busy_o,
    output logic              done_o
);
    phase_e             ph_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               done_q;

    assign accept_o = start_i && (ph_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= ST_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (ph_q)
                ST_IDLE: if (accept_o) begin
                    ph_q  <= ST_RUN;
                    cnt_q <= '0;
                end
                ST_RUN: begin
                    if (cnt_q == CNT_W'(ROUNDS - 1)) ph_q <= ST_FIN;
                    else                             cnt_q <= cnt_q + 1'b1;
                end
                ST_FIN: begin
                    ph_q   <= ST_IDLE;
                    done_q <= 1'b1;
                end
                default: ph_q <= ST_IDLE;
            endcase
        end
    end

    assign phase_o = ph_q;
    assign rnd_o   = cnt_q;
    assign busy_o  = (ph_q != ST_IDLE);
    assign done_o  = done_q;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R2
    fin_done_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == ST_FIN) |=> (done_q && ph_q == ST_IDLE));
    // R3
    ign_start_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == ST_RUN && start_i) |=>
            (ph_q == ST_FIN || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/fcx_cipher_core.sv
module fcx_cipher_core
    import fcx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  decrypt,
    input  logic [2*HALF_W-1:0]   blk_in,
    input  logic                  ld_we,
    input  logic [SEL_W-1:0]      ld_sel,
    input  logic [TBL_AW-1:0]     ld_addr,
    input  logic [HALF_W-1:0]     ld_data,
    output logic [2*HALF_W-1:0]   blk_out,
    output logic                  done,
    output logic                  busy
);
    logic              accept;
    phase_e            phase;
    logic [CNT_W-1:0]  rnd;
    logic              wr_ok;
    logic              dec_q;
    halves_t           st_q;
    logic [2*HALF_W-1:0] out_q;
    logic [IDX_W-1:0]  idx_a, idx_b;
    word_t             key_a, key_b, x, fx;

    assign wr_ok = ld_we && !busy;

    fcx_round_ctrl i_ctrl (
        .clk(clk), .rst(rst), .start_i(start), .accept_o(accept),
        .phase_o(phase), .rnd_o(rnd), .busy_o(busy), .done_o(done)
    );

    always_comb begin
        if (phase == ST_FIN) idx_a = dec_q ? IDX_W'(0) : IDX_W'(NSUB - 1);
        else                 idx_a = round_slot(rnd, dec_q);
        idx_b = dec_q ? IDX_W'(1) : IDX_W'(NSUB - 2);
    end

    fcx_key_store i_keys (
        .clk(clk), .rst(rst), .busy_i(busy), .wr_en(wr_ok), .wr_sel(ld_sel),
        .wr_addr(ld_addr), .wr_data(ld_data), .idx_a(idx_a), .idx_b(idx_b),
        .key_a(key_a), .key_b(key_b)
    );

    assign x = st_q.l ^ key_a;

    fcx_table_bank i_tables (
        .clk(clk), .wr_en(wr_ok), .wr_sel(ld_sel), .wr_addr(ld_addr),
        .wr_data(ld_data), .x(x), .fx(fx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            dec_q <= 1'b0;
            out_q <= '0;
        end else if (accept) begin
            st_q  <= halves_t'(blk_in);
            dec_q <= decrypt;
        end else if (phase == ST_RUN) begin
            st_q.l <= st_q.r ^ fx;
            st_q.r <= x;
        end else if (phase == ST_FIN) begin
            out_q <= {st_q.r ^ key_a, st_q.l ^ key_b};
        end
    end

    assign blk_out = out_q;

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(blk_out));
    // R2
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
endmodule

// File: tb/test_fcx_cipher_core.sv
module test_fcx_cipher_core;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        decrypt = 1'b0;
    logic [63:0] blk_in = '0;
    logic        ld_we = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [63:0] blk_out;
    logic        done, busy;

    fcx_cipher_core i_fcx_cipher_core (
        .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .blk_in(blk_in),
        .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
        .blk_out(blk_out), .done(done), .busy(busy)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench-side copies of what the block should hold
    logic [31:0] m_tbl [4][256];
    logic [31:0] m_sub [18];
    logic [31:0] m_key [14];

    typedef struct {
        logic [63:0] val;
        int          edge_cyc;
        logic        dec;
    } exp_t;
    exp_t sb_q [$];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ek(input int i);
        return m_sub[i] ^ m_key[i % 14];
    endfunction

    function automatic logic [31:0] ff(input logic [31:0] v);
        return ((m_tbl[0][v[31:24]] + m_tbl[1][v[23:16]]) ^ m_tbl[2][v[15:8]])
               + m_tbl[3][v[7:0]];
    endfunction

    function automatic logic [63:0] model(input logic [63:0] b, input logic dec);
        logic [31:0] l, r, xx;
        l = b[63:32];
        r = b[31:0];
        for (int i = 0; i < 16; i++) begin
            xx = l ^ ek(dec ? 17 - i : i);
            l  = r ^ ff(xx);
            r  = xx;
        end
        return dec ? {r ^ ek(0), l ^ ek(1)} : {r ^ ek(17), l ^ ek(16)};
    endfunction

    task automatic ld(input logic [2:0] s, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_sel = s; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    // R8: sel 0-3 tables, 4 subkeys, 5 key words
    task automatic load_all(input int seed_mode);
        for (int t = 0; t < 4; t++)
            for (int a = 0; a < 256; a++) begin
                logic [31:0] d;
                d = (seed_mode == 0) ? 32'(a * (t + 3)) ^ 32'h5a5a_0000 : $urandom;
                m_tbl[t][a] = d;
                ld(3'(t), 8'(a), d);
            end
        for (int i = 0; i < 18; i++) begin
            m_sub[i] = $urandom;
            ld(3'd4, 8'(i), m_sub[i]);
        end
        for (int i = 0; i < 14; i++) begin
            m_key[i] = (seed_mode == 0) ? 32'(i + 1) : $urandom;
            ld(3'd5, 8'(i), m_key[i]);
        end
    endtask

    task automatic start_op(input logic [63:0] b, input logic dec);
        exp_t e;
        @(negedge clk);
        start = 1'b1; blk_in = b; decrypt = dec;
        e.val = model(b, dec);
        e.edge_cyc = cyc + 1;
        e.dec = dec;
        sb_q.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output logic [63:0] res);
        while (!done) @(negedge clk);
        res = blk_out;
        @(negedge clk);
    endtask

    // monitor: pops expected results as done pulses appear
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R3 unexpected done act=%h exp=none", blk_out);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.dec ? "R5 decrypt result" : "R4 encrypt result", blk_out, e.val);
                check("R2 latency", 64'(cyc - e.edge_cyc), 64'd17);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] res, orig;
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset blk_out", blk_out, 64'd0);
        check("R1 reset done/busy", {62'd0, done, busy}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {blk_out[0], done, busy}, 64'd0);

        // structured tables and small key first (R6, R7)
        load_all(0);
        start_op(64'h0123_4567_89ab_cdef, 1'b0);
        check("R2 busy after start", {63'd0, busy}, 64'd1);
        wait_done(res);
        start_op(res, 1'b1);
        wait_done(res);
        check("R5 round trip", res, 64'h0123_4567_89ab_cdef);

        // random keys and blocks
        for (int k = 0; k < 2; k++) begin
            load_all(1);
            for (int j = 0; j < 4; j++) begin
                orig = {$urandom, $urandom};
                start_op(orig, 1'b0);
                wait_done(res);
                start_op(res, 1'b1);
                wait_done(res);
                check("R5 round trip", res, orig);
            end
            start_op({$urandom, $urandom}, 1'b1);
            wait_done(res);
        end

        // R3: start while busy is ignored
        start_op(64'hdead_beef_0000_1111, 1'b0);
        repeat (5) @(negedge clk);
        start = 1'b1; blk_in = 64'hffff_ffff_ffff_ffff; decrypt = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(res);
        repeat (25) @(negedge clk);
        check("R3 no extra done queued", 64'(sb_q.size()), 64'd0);

        // R9: writes during busy rejected (model untouched)
        start_op(64'h1111_2222_3333_4444, 1'b0);
        ld(3'd4, 8'd0, 32'hcafe_f00d);
        ld(3'd5, 8'd3, 32'h1234_5678);
        ld(3'd2, 8'h10, 32'h0bad_0bad);
        wait_done(res);
        start_op(64'h1111_2222_3333_4444, 1'b0);
        wait_done(res);
        check("R9 write during busy rejected", res, model(64'h1111_2222_3333_4444, 1'b0));

        // R8: out-of-range writes change nothing
        ld(3'd4, 8'd18, 32'hffff_0000);
        ld(3'd5, 8'd14, 32'h0000_ffff);
        ld(3'd6, 8'd0, 32'h7777_7777);
        ld(3'd7, 8'd1, 32'h8888_8888);
        start_op(64'h5555_aaaa_5555_aaaa, 1'b1);
        wait_done(res);
        check("R8 ignored writes", res, model(64'h5555_aaaa_5555_aaaa, 1'b1));
        // R8/R7: last key word in range is used (slot 13 folds into subkey 13)
        m_key[13] = 32'h0f0f_f0f0;
        ld(3'd5, 8'd13, m_key[13]);
        start_op(64'h5555_aaaa_5555_aaaa, 1'b1);
        wait_done(res);
        check("R7 key word 13 folded", res, model(64'h5555_aaaa_5555_aaaa, 1'b1));

        // R10: inputs captured at start; output held afterwards
        start_op(64'h0246_8ace_1357_9bdf, 1'b0);
        blk_in = '0; decrypt = 1'b1;
        wait_done(res);
        repeat (10) @(negedge clk);
        check("R10 output held", blk_out, res);
        check("R10 captured inputs", res, model(64'h0246_8ace_1357_9bdf, 1'b0));

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule